// File: doc/BRIEF.md
# Next-Address Microcode Sequencer

This block is the control half of a single-bus processor. A 256-word internal control store holds microinstructions. A microinstruction address register picks the current word. Every word names the address of the word that follows it. No counter adds one to the address. The current word is decoded into individual gating strobes for the datapath, and these strobes are combinational from the word.

The successor address is built from one of two bases. The first base is the word's own next-address field. The second base is the start address that an opcode decoder derives from the instruction register. Two flags in the word can then OR bits taken from the instruction onto that base. This gives a multi-way branch on the addressing mode in a single step. A third flag selects between the direct and indirect forms of the source operand.

Generic source-register and destination-register strobes are widened into per-register drive and load enables. The register number comes from the register fields of the instruction. An instruction ends when its last word points back at address 0, where the shared fetch routine starts.

Top module: `useq_ctrl`

## Requirements
- R1: While `rst_n` is low the address register is 0. Word 0 asserts `bus_pc_drv`, `ld_mar`, `mem_rd`, `alu_b_const`, `ld_z` and `alu_op`=4'b0001 (add). Every other strobe is low in word 0.
- R2: The fetch routine steps 0→1→2→3. Word 1 asserts `bus_z_drv`, `ld_pc`, `ld_y` and `wait_mem`. Word 2 asserts `bus_mdr_drv` and `ld_ir`.
- R3: When the current word asserts `wait_mem` and `mem_done` is 0, the address register holds its value at the clock edge.
- R4: The instruction fields are: opcode `ir_word[15:11]`, mode `ir_word[10:9]`, indirect flag `ir_word[8]`, source register `ir_word[7:4]`, destination register `ir_word[3:0]`. Word 3 dispatches on the opcode. Opcode 5'b00001 (add) maps to start address octal 101. Every other opcode maps to 0.
- R5: The mode dispatch ORs `ir_word[10]` into address bit 5 and `ir_word[9]` into address bit 4. It ORs bit 3 only for mode 00 with the indirect flag set. The mode codes are 00 register, 01 autoincrement, 10 autodecrement and 11 indexed. From base 101 the five targets are: register 101, register-indirect 111, autoincrement 121, autodecrement 141, indexed 161 (all octal).
- R6: The indirect-select flag ORs the inverse of `ir_word[8]` into address bit 0. In the autoincrement routine, the direct form therefore goes from 122 to 171 and skips the pointer fetch at 170. The indirect form goes from 122 to 170.
- R7: Any word that does not dispatch moves to its next-address field. The register-direct add routine runs 101→172→173→0. The autoincrement add routine runs 121→122→(170)→171→172→173→0. Unprogrammed words assert no strobe and return to 0.
- R8: `reg_drv` and `reg_ld` have one bit per register. A source strobe enables only the bit indexed by `ir_word[7:4]`. A destination strobe enables only the bit indexed by `ir_word[3:0]`.
- R9: At most one bus driver is active at a time, counting register drive. `mem_rd` and `mem_wr` are never both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ir_word | input | 16 | Current instruction register contents |
| mem_done | input | 1 | Memory operation complete |
| uaddr | output | 8 | Current microinstruction address |
| bus_pc_drv | output | 1 | PC drives the internal bus |
| bus_mdr_drv | output | 1 | MDR drives the internal bus |
| bus_z_drv | output | 1 | Z drives the internal bus |
| bus_tmp_drv | output | 1 | TEMP drives the internal bus |
| ld_pc | output | 1 | Load PC from bus |
| ld_ir | output | 1 | Load IR from bus |
| ld_z | output | 1 | Load Z from ALU |
| ld_mar | output | 1 | Load MAR from bus |
| ld_mdr | output | 1 | Load MDR from bus |
| ld_tmp | output | 1 | Load TEMP from bus |
| ld_y | output | 1 | Load Y from bus |
| alu_op | output | 4 | ALU function code |
| mem_rd | output | 1 | Memory read request |
| mem_wr | output | 1 | Memory write request |
| alu_b_const | output | 1 | ALU input A takes constant 4 instead of Y |
| wait_mem | output | 1 | Current word waits for memory completion |
| reg_drv | output | 16 | Per-register bus drive enables |
| reg_ld | output | 16 | Per-register load enables |

## Verification
On every cycle the assertions check four things. The address freezes during a memory wait. The add dispatch lands in the octal-101 block. The mode and indirect bits show up in the successor address whenever the instruction sets them. Bus drivers and memory strobes stay mutually exclusive. Only the bench scenarios can show the full address walk for each of the five source modes, in both the direct and indirect forms. The same is true of the per-register enables that follow the instruction's register fields, and of an unknown opcode falling back to fetch.

// File: rtl/useq_pkg.sv
package useq_pkg;

   localparam int UA_W = 8;
   localparam logic [UA_W-1:0] ADD_ENTRY = 8'o101;

   typedef enum logic [2:0] {
      SRC_NONE = 3'd0, SRC_PC = 3'd1, SRC_MDR = 3'd2, SRC_Z = 3'd3,
      SRC_RS = 3'd4, SRC_RD = 3'd5, SRC_TMP = 3'd6
   } bus_src_e;

   typedef enum logic [2:0] {
      DA_NONE = 3'd0, DA_PC = 3'd1, DA_IR = 3'd2, DA_Z = 3'd3,
      DA_RS = 3'd4, DA_RD = 3'd5
   } dst_a_e;

   typedef enum logic [2:0] {
      DB_NONE = 3'd0, DB_MAR = 3'd1, DB_MDR = 3'd2, DB_TMP = 3'd3,
      DB_Y = 3'd4
   } dst_b_e;

   localparam logic [3:0] ALU_ADD = 4'b0001;
   localparam logic [1:0] MEM_NONE = 2'b00;
   localparam logic [1:0] MEM_RD = 2'b01;
   localparam logic [1:0] MEM_WR = 2'b10;

   typedef struct packed {
      logic [UA_W-1:0] nxt;
      bus_src_e        src;
      dst_a_e          da;
      dst_b_e          db;
      logic [3:0]      alu;
      logic [1:0]      mem;
      logic            sel4;
      logic            wmfc;
      logic            or_ind;
      logic            or_mode;
      logic            dispatch;
   } uword_t;

   function automatic uword_t uword_at(input logic [UA_W-1:0] a);
      uword_t w;
      w = '0;
      case (a)
         8'o000: begin
            w.nxt = 8'o001; w.src = SRC_PC; w.db = DB_MAR; w.mem = MEM_RD;
            w.sel4 = 1'b1; w.alu = ALU_ADD; w.da = DA_Z;
         end
         8'o001: begin
            w.nxt = 8'o002; w.src = SRC_Z; w.da = DA_PC; w.db = DB_Y;
            w.wmfc = 1'b1;
         end
         8'o002: begin
            w.nxt = 8'o003; w.src = SRC_MDR; w.da = DA_IR;
         end
         8'o003: begin
            w.dispatch = 1'b1; w.or_mode = 1'b1;
         end
         8'o101: begin
            w.nxt = 8'o172; w.src = SRC_RS; w.db = DB_Y;
         end
         8'o121: begin
            w.nxt = 8'o122; w.src = SRC_RS; w.db = DB_MAR; w.mem = MEM_RD;
            w.sel4 = 1'b1; w.alu = ALU_ADD; w.da = DA_Z;
         end
         8'o122: begin
            w.nxt = 8'o170; w.src = SRC_Z; w.da = DA_RS; w.wmfc = 1'b1;
            w.or_ind = 1'b1;
         end
         8'o170: begin
            w.nxt = 8'o171; w.src = SRC_MDR; w.db = DB_MAR; w.mem = MEM_RD;
            w.wmfc = 1'b1;
         end
         8'o171: begin
            w.nxt = 8'o172; w.src = SRC_MDR; w.db = DB_Y;
         end
         8'o172: begin
            w.nxt = 8'o173; w.src = SRC_RD; w.alu = ALU_ADD; w.da = DA_Z;
         end
         8'o173: begin
            w.nxt = 8'o000; w.src = SRC_Z; w.da = DA_RD;
         end
         default: w = '0;
      endcase
      return w;
   endfunction

endpackage

// File: rtl/useq_store.sv
module useq_store
   import useq_pkg::*;
#(
   parameter int DEPTH = 256
) (
   input  logic [UA_W-1:0] addr,
   output uword_t          word
);

   localparam int FULL = 2 ** UA_W;

   generate
      if (DEPTH >= FULL) begin : g_full
         always_comb word = uword_at(addr);
      end else begin : g_part
         always_comb word = (int'(addr) < DEPTH) ? uword_at(addr) : '0;
      end
   endgenerate

endmodule

// File: rtl/useq_next.sv
module useq_next
   import useq_pkg::*;
#(
   parameter int              OPC_W   = 5,
   parameter logic [OPC_W-1:0] ADD_OPC = 5'd1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [UA_W-1:0] nxt_field,
   input  logic            dispatch,
   input  logic            or_mode,
   input  logic            or_ind,
   input  logic            wmfc,
   input  logic            mem_done,
   input  logic [7:0]      ir_hi,
   output logic [UA_W-1:0] uaddr
);

   logic [OPC_W-1:0] opc;
   logic [UA_W-1:0]  start_addr, base, nxt;
   logic             stall;

   assign opc        = ir_hi[7 -: OPC_W];
   assign start_addr = (opc == ADD_OPC) ? ADD_ENTRY : '0;
   assign stall      = wmfc & ~mem_done;

   always_comb begin
      base = dispatch ? start_addr : nxt_field;
      nxt  = base;
      if (or_mode) begin
         nxt[5] = nxt[5] | ir_hi[2];
         nxt[4] = nxt[4] | ir_hi[1];
         nxt[3] = nxt[3] | (~ir_hi[2] & ~ir_hi[1] & ir_hi[0]);
      end
      if (or_ind) nxt[0] = nxt[0] | ~ir_hi[0];
   end

   always_ff @(posedge clk) begin
      if (!rst_n)      uaddr <= '0;
      else if (!stall) uaddr <= nxt;
   end

   p_stall_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (wmfc && !mem_done) |=> $stable(uaddr));

   p_dispatch_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (dispatch && !stall && opc == ADD_OPC) |=> (uaddr[7:6] == 2'b01 && uaddr[2:0] == 3'b001));

   p_mode_hi_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (or_mode && !stall && ir_hi[2]) |=> uaddr[5]);

   p_mode_lo_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (or_mode && !stall && ir_hi[1]) |=> uaddr[4]);

   p_orind_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (or_ind && !stall && !ir_hi[0]) |=> uaddr[0]);

   p_next_field_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (!dispatch && !or_mode && !or_ind && !stall) |=> (uaddr == $past(nxt_field)));

endmodule

// File: rtl/useq_gate_dec.sv
module useq_gate_dec
   import useq_pkg::*;
#(
   parameter int NREG = 16
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  bus_src_e                 src,
   input  dst_a_e                   da,
   input  dst_b_e                   db,
   input  logic [1:0]               mem,
   input  logic [$clog2(NREG)-1:0]  rs_sel,
   input  logic [$clog2(NREG)-1:0]  rd_sel,
   output logic                     bus_pc_drv,
   output logic                     bus_mdr_drv,
   output logic                     bus_z_drv,
   output logic                     bus_tmp_drv,
   output logic                     ld_pc,
   output logic                     ld_ir,
   output logic                     ld_z,
   output logic                     ld_mar,
   output logic                     ld_mdr,
   output logic                     ld_tmp,
   output logic                     ld_y,
   output logic                     mem_rd,
   output logic                     mem_wr,
   output logic [NREG-1:0]          reg_drv,
   output logic [NREG-1:0]          reg_ld
);

   localparam int RSEL_W = $clog2(NREG);

   logic rs_out, rd_out, rs_in, rd_in;

   assign bus_pc_drv  = (src == SRC_PC);
   assign bus_mdr_drv = (src == SRC_MDR);
   assign bus_z_drv   = (src == SRC_Z);
   assign bus_tmp_drv = (src == SRC_TMP);
   assign rs_out      = (src == SRC_RS);
   assign rd_out      = (src == SRC_RD);

   assign ld_pc = (da == DA_PC);
   assign ld_ir = (da == DA_IR);
   assign ld_z  = (da == DA_Z);
   assign rs_in = (da == DA_RS);
   assign rd_in = (da == DA_RD);

   assign ld_mar = (db == DB_MAR);
   assign ld_mdr = (db == DB_MDR);
   assign ld_tmp = (db == DB_TMP);
   assign ld_y   = (db == DB_Y);

   assign mem_rd = (mem == MEM_RD);
   assign mem_wr = (mem == MEM_WR);

   generate
      for (genvar i = 0; i < NREG; i++) begin : g_reg
         assign reg_drv[i] = (rs_out && rs_sel == RSEL_W'(i)) ||
                             (rd_out && rd_sel == RSEL_W'(i));
         assign reg_ld[i]  = (rs_in && rs_sel == RSEL_W'(i)) ||
                             (rd_in && rd_sel == RSEL_W'(i));
      end
   endgenerate

   p_drv_onehot_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(reg_drv));

   p_ld_onehot_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(reg_ld));

   p_bus_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({bus_pc_drv, bus_mdr_drv, bus_z_drv, bus_tmp_drv, |reg_drv}));

   p_rw_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !(mem_rd && mem_wr));

endmodule

// File: rtl/useq_ctrl.sv
module useq_ctrl
   import useq_pkg::*;
#(
   parameter int                IR_W    = 16,
   parameter int                NREG    = 16,
   parameter int                DEPTH   = 256,
   parameter int                OPC_W   = 5,
   parameter logic [OPC_W-1:0]  ADD_OPC = 5'd1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [IR_W-1:0]   ir_word,
   input  logic              mem_done,
   output logic [UA_W-1:0]   uaddr,
   output logic              bus_pc_drv,
   output logic              bus_mdr_drv,
   output logic              bus_z_drv,
   output logic              bus_tmp_drv,
   output logic              ld_pc,
   output logic              ld_ir,
   output logic              ld_z,
   output logic              ld_mar,
   output logic              ld_mdr,
   output logic              ld_tmp,
   output logic              ld_y,
   output logic [3:0]        alu_op,
   output logic              mem_rd,
   output logic              mem_wr,
   output logic              alu_b_const,
   output logic              wait_mem,
   output logic [NREG-1:0]   reg_drv,
   output logic [NREG-1:0]   reg_ld
);

   localparam int RSEL_W = $clog2(NREG);

   generate
      if (IR_W != 16) begin : g_bad_ir
         $error("useq_ctrl: instruction layout needs IR_W of 16");
      end
      if (RSEL_W != 4) begin : g_bad_reg
         $error("useq_ctrl: register fields are 4 bits, NREG must be 9..16");
      end
      if (OPC_W != 5) begin : g_bad_opc
         $error("useq_ctrl: opcode field is IR[15:11]");
      end
      if (DEPTH <= 123 || DEPTH > 2 ** UA_W) begin : g_bad_depth
         $error("useq_ctrl: DEPTH must cover the programmed routines");
      end
   endgenerate

   uword_t cur;

   useq_store #(.DEPTH(DEPTH)) u_store (
      .addr (uaddr),
      .word (cur)
   );

   useq_next #(.OPC_W(OPC_W), .ADD_OPC(ADD_OPC)) u_next (
      .clk       (clk),
      .rst_n     (rst_n),
      .nxt_field (cur.nxt),
      .dispatch  (cur.dispatch),
      .or_mode   (cur.or_mode),
      .or_ind    (cur.or_ind),
      .wmfc      (cur.wmfc),
      .mem_done  (mem_done),
      .ir_hi     (ir_word[15:8]),
      .uaddr     (uaddr)
   );

   useq_gate_dec #(.NREG(NREG)) u_gate (
      .clk         (clk),
      .rst_n       (rst_n),
      .src         (cur.src),
      .da          (cur.da),
      .db          (cur.db),
      .mem         (cur.mem),
      .rs_sel      (ir_word[7:4]),
      .rd_sel      (ir_word[3:0]),
      .bus_pc_drv  (bus_pc_drv),
      .bus_mdr_drv (bus_mdr_drv),
      .bus_z_drv   (bus_z_drv),
      .bus_tmp_drv (bus_tmp_drv),
      .ld_pc       (ld_pc),
      .ld_ir       (ld_ir),
      .ld_z        (ld_z),
      .ld_mar      (ld_mar),
      .ld_mdr      (ld_mdr),
      .ld_tmp      (ld_tmp),
      .ld_y        (ld_y),
      .mem_rd      (mem_rd),
      .mem_wr      (mem_wr),
      .reg_drv     (reg_drv),
      .reg_ld      (reg_ld)
   );

   assign alu_op      = cur.alu;
   assign alu_b_const = cur.sel4;
   assign wait_mem    = cur.wmfc;

endmodule

// File: tb/useq_ctrl_tb.sv
module useq_ctrl_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] ir_word = '0;
   logic        mem_done = 1'b1;
   logic [7:0]  uaddr;
   logic        bus_pc_drv, bus_mdr_drv, bus_z_drv, bus_tmp_drv;
   logic        ld_pc, ld_ir, ld_z, ld_mar, ld_mdr, ld_tmp, ld_y;
   logic [3:0]  alu_op;
   logic        mem_rd, mem_wr, alu_b_const, wait_mem;
   logic [15:0] reg_drv, reg_ld;

   int checks = 0;
   int errors = 0;
   int cyc = 0;

   always #10 clk = ~clk;

   useq_ctrl u_dut (
      .clk(clk), .rst_n(rst_n), .ir_word(ir_word), .mem_done(mem_done),
      .uaddr(uaddr), .bus_pc_drv(bus_pc_drv), .bus_mdr_drv(bus_mdr_drv),
      .bus_z_drv(bus_z_drv), .bus_tmp_drv(bus_tmp_drv), .ld_pc(ld_pc),
      .ld_ir(ld_ir), .ld_z(ld_z), .ld_mar(ld_mar), .ld_mdr(ld_mdr),
      .ld_tmp(ld_tmp), .ld_y(ld_y), .alu_op(alu_op), .mem_rd(mem_rd),
      .mem_wr(mem_wr), .alu_b_const(alu_b_const), .wait_mem(wait_mem),
      .reg_drv(reg_drv), .reg_ld(reg_ld)
   );

   // row: {restart, mode/ind, expected address, drive sel, load sel}
   // sel: 0 none, 1 source register, 2 destination register
   function automatic logic [15:0] mk(input logic f, input logic [2:0] m,
                                      input logic [7:0] a, input logic [1:0] d,
                                      input logic [1:0] l);
      return {f, m, a, d, l};
   endfunction

   localparam int NROW = 47;
   localparam logic [15:0] TBL [NROW] = '{
      // register direct: R5, R7
      mk(1,3'b000,8'o000,0,0), mk(0,3'b000,8'o001,0,0), mk(0,3'b000,8'o002,0,0),
      mk(0,3'b000,8'o003,0,0), mk(0,3'b000,8'o101,1,0), mk(0,3'b000,8'o172,2,0),
      mk(0,3'b000,8'o173,0,2), mk(0,3'b000,8'o000,0,0),
      // register indirect
      mk(1,3'b001,8'o000,0,0), mk(0,3'b001,8'o001,0,0), mk(0,3'b001,8'o002,0,0),
      mk(0,3'b001,8'o003,0,0), mk(0,3'b001,8'o111,0,0), mk(0,3'b001,8'o000,0,0),
      // autoincrement direct
      mk(1,3'b010,8'o000,0,0), mk(0,3'b010,8'o001,0,0), mk(0,3'b010,8'o002,0,0),
      mk(0,3'b010,8'o003,0,0), mk(0,3'b010,8'o121,1,0), mk(0,3'b010,8'o122,0,1),
      mk(0,3'b010,8'o171,0,0), mk(0,3'b010,8'o172,2,0), mk(0,3'b010,8'o173,0,2),
      mk(0,3'b010,8'o000,0,0),
      // autoincrement indirect
      mk(1,3'b011,8'o000,0,0), mk(0,3'b011,8'o001,0,0), mk(0,3'b011,8'o002,0,0),
      mk(0,3'b011,8'o003,0,0), mk(0,3'b011,8'o121,1,0), mk(0,3'b011,8'o122,0,1),
      mk(0,3'b011,8'o170,0,0), mk(0,3'b011,8'o171,0,0), mk(0,3'b011,8'o172,2,0),
      mk(0,3'b011,8'o173,0,2), mk(0,3'b011,8'o000,0,0),
      // autodecrement
      mk(1,3'b100,8'o000,0,0), mk(0,3'b100,8'o001,0,0), mk(0,3'b100,8'o002,0,0),
      mk(0,3'b100,8'o003,0,0), mk(0,3'b100,8'o141,0,0), mk(0,3'b100,8'o000,0,0),
      // indexed
      mk(1,3'b110,8'o000,0,0), mk(0,3'b110,8'o001,0,0), mk(0,3'b110,8'o002,0,0),
      mk(0,3'b110,8'o003,0,0), mk(0,3'b110,8'o161,0,0), mk(0,3'b110,8'o000,0,0)
   };

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic do_reset(input logic [15:0] ir);
      rst_n   = 1'b0;
      ir_word = ir;
      @(negedge clk);
      @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic step();
      @(posedge clk);
      @(negedge clk);
   endtask

   function automatic logic [15:0] sel_vec(input logic [1:0] s, input logic [3:0] rs,
                                           input logic [3:0] rd);
      if (s == 2'd1) return 16'(1) << rs;
      if (s == 2'd2) return 16'(1) << rd;
      return 16'h0;
   endfunction

   always @(posedge clk) begin
      cyc++;
      if (cyc > 20000) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual %0d expected below 20000 cycles", cyc);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      @(negedge clk);
      // table walk: five source modes plus the register-indirect entry (R5 R6 R7 R8)
      for (int i = 0; i < NROW; i++) begin
         logic [15:0] row;
         logic [2:0]  m;
         logic [3:0]  rs, rd;
         row = TBL[i];
         m   = row[14:12];
         rs  = 4'(m + 3'd3);
         rd  = 4'(4'd12 - {1'b0, m});
         if (row[15]) do_reset({5'b00001, m, rs, rd});
         else step();
         chk("R5/R6/R7 address", {24'h0, uaddr}, {24'h0, row[11:4]});
         chk("R8 reg_drv", {16'h0, reg_drv}, {16'h0, sel_vec(row[3:2], rs, rd)});
         chk("R8 reg_ld", {16'h0, reg_ld}, {16'h0, sel_vec(row[1:0], rs, rd)});
         chk("R9 rd/wr", {31'h0, mem_rd & mem_wr}, 32'h0);
      end

      // R1: reset state and fetch word
      do_reset({5'b00001, 3'b000, 4'd2, 4'd9});
      chk("R1 uaddr", {24'h0, uaddr}, 32'h0);
      chk("R1 fetch strobes",
          {25'h0, bus_pc_drv, ld_mar, mem_rd, alu_b_const, ld_z, bus_z_drv, ld_pc},
          {25'h0, 7'b1111100});
      chk("R1 alu_op", {28'h0, alu_op}, 32'h1);
      chk("R1 quiet", {16'h0, reg_drv | reg_ld}, 32'h0);

      // R2 then R3: word 1 stalls without mem_done
      step();
      chk("R2 word1 strobes", {28'h0, bus_z_drv, ld_pc, ld_y, wait_mem}, 32'hF);
      mem_done = 1'b0;
      for (int k = 0; k < 3; k++) begin
         step();
         chk("R3 stall hold", {24'h0, uaddr}, 32'o001);
      end
      mem_done = 1'b1;
      step();
      chk("R3 release", {24'h0, uaddr}, 32'o002);
      chk("R2 word2 strobes", {30'h0, bus_mdr_drv, ld_ir}, 32'h3);

      // R4: unknown opcode dispatches to 0 with mode bits ORed, then fetch
      do_reset({5'b00000, 3'b110, 4'd1, 4'd2});
      step(); step(); step();
      chk("R4 word3", {24'h0, uaddr}, 32'o003);
      step();
      chk("R4 unknown opcode", {24'h0, uaddr}, 32'o060);
      step();
      chk("R7 blank returns", {24'h0, uaddr}, 32'h0);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule